// File: doc/BRIEF.md
# Curve Accelerator Control Register Block

This block is the memory-mapped register front end for an elliptic-curve arithmetic engine. A host issues single-cycle 32-bit word reads and writes on a simple strobe bus. Through it the host loads three eight-word operand windows (scalar, X coordinate, Y coordinate), picks a key length and an operating mode, and launches a calculation by setting a start bit. The block then sends a one-cycle launch pulse and the mode to the engine.

When the engine signals completion, the block clears the start bit, latches the verification flag and raises a completion interrupt. The interrupt has a raw bit, an enable bit, a masked status bit and a write-one-to-clear register. A write-only trigger in the configuration word returns everything to idle. In this project the engine is a stub. It finishes `ENGINE_LAT` cycles after launch and reports a passing verification only for modes that verify. Reads return data one cycle after the read strobe.

Top module: `curve_csr`

## Requirements
- R1: After reset, the configuration word (byte offset 0x1C) reads 0x8000_0000. The raw (0x0C), status (0x10) and enable (0x14) registers read 0. The version word (0xFC) reads 0x0220_1240 (decimal 35656256 in bits 27:0).
- R2: The engine's done event sets raw bit 0. Writing 1 to bit 0 of the clear register (0x18) clears it, and the clear register always reads 0. If a clear and a done event fall in the same cycle, the raw bit ends up set.
- R3: Status bit 0 equals raw AND enable. Enable bit 0 is read/write. Output `irq_o` follows the status bit.
- R4: Writing 1 to configuration bit 0 while idle sets the start bit and drives `eng_start_o` high for exactly one cycle. The start bit clears by itself when the engine reports done.
- R5: Configuration bit 2 is key length (0 = 192-bit, 1 = 256-bit) and drives `eng_keylen_o`. Bits 3 and 4 are plain storage. Bits 7:5 are the mode and drive `eng_mode_o`. Bit 31 is storage that resets to 1. Bit 1 always reads 0.
- R6: Writing 1 to configuration bit 1 clears start, raw and the result, and aborts the engine so that no done event follows. It changes no other field and wins over a start bit written in the same word. Operand contents survive it.
- R7: While the start bit is set, a configuration write without bit 1 set has no effect.
- R8: Configuration bit 8 is read-only. It is loaded on done with the engine's verification flag; the stub reports 1 exactly when mode bit 1 is set (modes 2, 3, 6, 7). It reads 0 until a calculation completes.
- R9: The scalar, X and Y windows at 0x100, 0x120 and 0x140 each hold 8 read/write words. All read data appears on `bus_rdata` with `bus_rvalid` one cycle after `bus_rd`.
- R10: Unmapped and reserved offsets (for example 0x00, 0x20, 0x160) read 0, and writes to them have no effect. The version word ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 9 | Byte address (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_o | output | 1 | Masked completion interrupt |
| eng_start_o | output | 1 | One-cycle launch pulse to the engine |
| eng_mode_o | output | 3 | Operating mode to the engine |
| eng_keylen_o | output | 1 | Key length select to the engine |

## Verification
The bench writes to the configuration word while a calculation is running. A block that lets these writes through would change the mode or start a second launch. It issues the soft reset both during a run and together with a start bit. A wrong block would let a late done event raise the interrupt, or would still launch the engine. It places a clear write on the exact cycle of the done event, where a wrong priority loses the completion. It also checks that the verification flag follows the mode and is wiped by the soft reset, and that operands survive that reset.

// File: rtl/curve_csr_pkg.sv
package curve_csr_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 9;
  localparam int unsigned WIDX_W   = ADDR_W - 2;
  localparam int unsigned OPND_WORDS = 8;
  localparam int unsigned OPND_SETS  = 3;
  localparam int unsigned OPND_TOTAL = OPND_WORDS * OPND_SETS;
  localparam int unsigned OPND_AW    = $clog2(OPND_TOTAL);
  localparam int unsigned MODE_W   = 3;

  // word indices (byte offset / 4)
  localparam logic [WIDX_W-1:0] W_RAW  = 7'd3;
  localparam logic [WIDX_W-1:0] W_STAT = 7'd4;
  localparam logic [WIDX_W-1:0] W_ENA  = 7'd5;
  localparam logic [WIDX_W-1:0] W_CLR  = 7'd6;
  localparam logic [WIDX_W-1:0] W_CFG  = 7'd7;
  localparam logic [WIDX_W-1:0] W_VER  = 7'd63;
  localparam logic [WIDX_W-1:0] W_OPND = 7'd64;

  typedef struct packed {
    logic             mclk_force;
    logic [MODE_W-1:0] mode;
    logic             clk_force;
    logic             secure;
    logic             keylen;
  } cfg_fields_t;
endpackage

// File: rtl/curve_csr_opmem.sv
module curve_csr_opmem
  import curve_csr_pkg::*;
#(
  parameter int unsigned DEPTH = OPND_TOTAL,
  parameter int unsigned WIDTH = DATA_W,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // single-port, read-first, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/curve_engine_stub.sv
module curve_engine_stub
  import curve_csr_pkg::*;
#(
  parameter int unsigned LAT = 8,
  localparam int unsigned CW = $clog2(LAT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              abort_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              done_o,
  output logic              verify_o
);
  logic          running_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || abort_i) begin
      running_q <= 1'b0;
      cnt_q     <= '0;
      done_o    <= 1'b0;
      verify_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i && !running_q) begin
        running_q <= 1'b1;
        cnt_q     <= CW'(LAT - 1);
        verify_o  <= mode_i[1];
      end else if (running_q) begin
        if (cnt_q == '0) begin
          running_q <= 1'b0;
          done_o    <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  AST_LAUNCH_RUNS: assert property (@(posedge clk) disable iff (rst)
    (start_i && !abort_i && !running_q) |=> running_q); // R4
  AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !running_q); // R4
endmodule

// File: rtl/curve_csr_ctrl.sv
module curve_csr_ctrl
  import curve_csr_pkg::*;
#(
  parameter logic [27:0] VERSION = 28'd35656256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [WIDX_W-1:0] widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              done_i,
  input  logic              verify_i,
  output logic              eng_start_o,
  output logic              abort_o,
  output logic [MODE_W-1:0] mode_o,
  output logic              keylen_o,
  output logic              irq_o
);
  cfg_fields_t cfg_q;
  logic start_q, raw_q, ena_q, result_q;

  logic cfg_wr, soft_rst, cfg_take;
  assign cfg_wr   = wr_i && (widx_i == W_CFG);
  assign soft_rst = cfg_wr && wdata_i[1];
  assign cfg_take = cfg_wr && !wdata_i[1] && !start_q;
  assign abort_o  = soft_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '{mclk_force: 1'b1, default: '0};
      start_q     <= 1'b0;
      raw_q       <= 1'b0;
      ena_q       <= 1'b0;
      result_q    <= 1'b0;
      eng_start_o <= 1'b0;
    end else begin
      eng_start_o <= 1'b0;
      if (wr_i && widx_i == W_ENA) ena_q <= wdata_i[0];
      if (soft_rst) begin
        start_q  <= 1'b0;
        raw_q    <= 1'b0;
        result_q <= 1'b0;
      end else begin
        if (done_i) begin
          start_q  <= 1'b0;
          raw_q    <= 1'b1;
          result_q <= verify_i;
        end else if (wr_i && widx_i == W_CLR && wdata_i[0]) begin
          raw_q <= 1'b0;
        end
        if (cfg_take) begin
          cfg_q.keylen     <= wdata_i[2];
          cfg_q.secure     <= wdata_i[3];
          cfg_q.clk_force  <= wdata_i[4];
          cfg_q.mode       <= wdata_i[7:5];
          cfg_q.mclk_force <= wdata_i[31];
          if (wdata_i[0]) begin
            start_q     <= 1'b1;
            eng_start_o <= 1'b1;
          end
        end
      end
    end
  end

  assign mode_o   = cfg_q.mode;
  assign keylen_o = cfg_q.keylen;
  assign irq_o    = raw_q & ena_q;

  always_comb begin
    rdata_o = '0;
    unique case (widx_i)
      W_RAW:  rdata_o[0] = raw_q;
      W_STAT: rdata_o[0] = raw_q & ena_q;
      W_ENA:  rdata_o[0] = ena_q;
      W_CFG:  rdata_o = {cfg_q.mclk_force, 22'd0, result_q, cfg_q.mode,
                         cfg_q.clk_force, cfg_q.secure, cfg_q.keylen, 1'b0, start_q};
      W_VER:  rdata_o = {4'd0, VERSION};
      default: rdata_o = '0;
    endcase
  end

  AST_DONE_DROPS_START: assert property (@(posedge clk) disable iff (rst)
    done_i |=> !start_q); // R4
  AST_DONE_SETS_RAW: assert property (@(posedge clk) disable iff (rst)
    (done_i && !soft_rst) |=> raw_q); // R2
  AST_BUSY_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (start_q && cfg_wr && !wdata_i[1]) |=> ($stable(cfg_q) && start_q)); // R7
  AST_SOFT_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!start_q && !raw_q && !result_q)); // R6
  AST_START_PULSE_SHORT: assert property (@(posedge clk) disable iff (rst)
    eng_start_o |=> !eng_start_o); // R4
endmodule

// File: rtl/curve_csr.sv
module curve_csr
  import curve_csr_pkg::*;
#(
  parameter int unsigned ENGINE_LAT = 8,
  parameter logic [27:0] VERSION    = 28'd35656256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic              irq_o,
  output logic              eng_start_o,
  output logic [MODE_W-1:0] eng_mode_o,
  output logic              eng_keylen_o
);
  logic [WIDX_W-1:0]  widx;
  logic               is_opnd;
  logic [OPND_AW-1:0] opnd_a;
  logic [DATA_W-1:0]  ctrl_rd, mem_rd, reg_rd_q;
  logic               sel_mem_q, rd_q;
  logic               eng_done, eng_verify, eng_abort;

  assign widx    = bus_addr[ADDR_W-1:2];
  assign opnd_a  = OPND_AW'(widx - W_OPND);
  assign is_opnd = (widx >= W_OPND) && (widx < W_OPND + WIDX_W'(OPND_TOTAL));

  curve_csr_opmem #(.DEPTH(OPND_TOTAL), .WIDTH(DATA_W)) u_opmem (
    .clk   (clk),
    .we    (bus_wr && is_opnd),
    .addr  (opnd_a),
    .wdata (bus_wdata),
    .rdata (mem_rd)
  );

  curve_csr_ctrl #(.VERSION(VERSION)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_i        (bus_wr),
    .widx_i      (widx),
    .wdata_i     (bus_wdata),
    .rdata_o     (ctrl_rd),
    .done_i      (eng_done),
    .verify_i    (eng_verify),
    .eng_start_o (eng_start_o),
    .abort_o     (eng_abort),
    .mode_o      (eng_mode_o),
    .keylen_o    (eng_keylen_o),
    .irq_o       (irq_o)
  );

  curve_engine_stub #(.LAT(ENGINE_LAT)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .start_i  (eng_start_o),
    .abort_i  (eng_abort),
    .mode_i   (eng_mode_o),
    .done_o   (eng_done),
    .verify_o (eng_verify)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q      <= 1'b0;
      sel_mem_q <= 1'b0;
      reg_rd_q  <= '0;
    end else begin
      rd_q      <= bus_rd;
      sel_mem_q <= bus_rd && is_opnd;
      reg_rd_q  <= (bus_rd && !is_opnd) ? ctrl_rd : '0;
    end
  end

  assign bus_rvalid = rd_q;
  assign bus_rdata  = sel_mem_q ? mem_rd : reg_rd_q;

  AST_RVALID_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> bus_rvalid); // R9
  AST_IRQ_NEEDS_ENGINE: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> ($past(eng_done) || $past(bus_wr))); // R3
endmodule

// File: tb/curve_csr_tb.sv
module curve_csr_tb;
  localparam int LAT = 8;
  localparam logic [8:0] A_RAW = 9'h00C, A_STAT = 9'h010, A_ENA = 9'h014,
                         A_CLR = 9'h018, A_CFG = 9'h01C, A_VER = 9'h0FC;

  logic clk = 1'b0, rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [8:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq_o, eng_start_o, eng_keylen_o;
  logic [2:0] eng_mode_o;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  curve_csr #(.ENGINE_LAT(LAT)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .irq_o(irq_o), .eng_start_o(eng_start_o), .eng_mode_o(eng_mode_o),
    .eng_keylen_o(eng_keylen_o)
  );

  // monitor: pops scoreboard on each returned read
  always @(negedge clk) begin
    if (!rst && bus_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R9 unexpected read data actual %h expected none", bus_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, e);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    bus_read(A_CFG,  32'h8000_0000, "R1 cfg reset");
    bus_read(A_RAW,  32'h0, "R1 raw reset");
    bus_read(A_STAT, 32'h0, "R1 status reset");
    bus_read(A_ENA,  32'h0, "R1 enable reset");
    bus_read(A_VER,  32'h0220_1240, "R1 version");
    chk(32'(irq_o), 32'h0, "R3 irq at reset");

    // R9 operand windows
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 8; w++)
        bus_write(9'(9'h100 + s*32 + w*4), 32'hA500_0000 ^ (s << 8) ^ (w * 32'h0101_0011));
    for (int s = 2; s >= 0; s--)
      for (int w = 0; w < 8; w++)
        bus_read(9'(9'h100 + s*32 + w*4), 32'hA500_0000 ^ (s << 8) ^ (w * 32'h0101_0011),
                 "R9 operand readback");

    // R10 unmapped and version writes
    bus_write(9'h000, 32'hFFFF_FFFF);
    bus_write(9'h020, 32'hFFFF_FFFF);
    bus_write(9'h160, 32'hFFFF_FFFF);
    bus_write(A_VER,  32'h0000_0000);
    bus_read(9'h000, 32'h0, "R10 offset 0x00");
    bus_read(9'h020, 32'h0, "R10 offset 0x20");
    bus_read(9'h160, 32'h0, "R10 offset 0x160");
    bus_read(A_VER,  32'h0220_1240, "R10 version ignores write");
    bus_read(9'h15C, 32'hA500_0200 ^ (7 * 32'h0101_0011), "R10 operand untouched");

    // R5 config fields: mode 5, bits 4,3,2 set, bit31 cleared, bit1 reads 0
    bus_write(A_CFG, 32'h0000_00BC);
    chk(32'(eng_mode_o), 32'd5, "R5 eng_mode_o");
    chk(32'(eng_keylen_o), 32'd1, "R5 eng_keylen_o");
    bus_read(A_CFG, 32'h0000_00BC, "R5 cfg readback");
    bus_write(A_CFG, 32'h8000_0040);
    bus_read(A_CFG, 32'h8000_0040, "R5 cfg mode2 bit31");

    // R4 launch in verify mode 2
    bus_write(A_CFG, 32'h8000_0041);
    chk(32'(eng_start_o), 32'd1, "R4 start pulse high");
    @(negedge clk);
    chk(32'(eng_start_o), 32'd0, "R4 start pulse one cycle");
    bus_read(A_CFG, 32'h8000_0041, "R4 start bit set while busy");
    // R7 busy write ignored
    bus_write(A_CFG, 32'h0000_00E0);
    chk(32'(eng_mode_o), 32'd2, "R7 mode held while busy");
    bus_read(A_CFG, 32'h8000_0041, "R7 cfg unchanged while busy");
    repeat (LAT + 8) @(negedge clk);
    bus_read(A_CFG,  32'h8000_0140, "R4 R8 start cleared result set");
    bus_read(A_RAW,  32'h1, "R2 raw set on done");
    bus_read(A_STAT, 32'h0, "R3 status masked");
    chk(32'(irq_o), 32'h0, "R3 irq masked");

    // R3 enable, R2 clear
    bus_write(A_ENA, 32'h1);
    bus_read(A_STAT, 32'h1, "R3 status enabled");
    chk(32'(irq_o), 32'h1, "R3 irq asserted");
    bus_write(A_CLR, 32'h1);
    chk(32'(irq_o), 32'h0, "R2 irq after clear");
    bus_read(A_RAW, 32'h0, "R2 raw cleared");
    bus_read(A_CLR, 32'h0, "R2 clear reads 0");

    // R8 non-verify mode gives result 0
    bus_write(A_CFG, 32'h8000_0001);
    repeat (LAT + 8) @(negedge clk);
    bus_read(A_CFG, 32'h8000_0000, "R8 result 0 for multiply");
    chk(32'(irq_o), 32'h1, "R3 irq on second done");
    bus_write(A_CLR, 32'h1);

    // R6 soft reset during run
    bus_write(A_CFG, 32'h8000_0041);
    bus_write(A_CFG, 32'h0000_0002);
    bus_read(A_CFG, 32'h8000_0040, "R6 abort clears start only");
    repeat (LAT + 8) @(negedge clk);
    bus_read(A_RAW, 32'h0, "R6 no done after abort");
    chk(32'(irq_o), 32'h0, "R6 irq quiet after abort");
    bus_read(9'h100, 32'hA500_0000, "R6 operands kept");

    // R6 reset wins over start in same word
    bus_write(A_CFG, 32'h8000_0043);
    chk(32'(eng_start_o), 32'd0, "R6 no launch with reset");
    bus_read(A_CFG, 32'h8000_0040, "R6 start not set");

    // R2 clear on the done cycle: set wins
    bus_write(A_CFG, 32'h8000_0041);
    repeat (LAT) @(negedge clk);
    bus_write(A_CLR, 32'h1);
    bus_read(A_RAW, 32'h1, "R2 done beats clear");
    bus_read(A_CFG, 32'h8000_0140, "R8 result after verify");

    // R6 soft reset while idle wipes result and raw
    bus_write(A_CFG, 32'h0000_0002);
    bus_read(A_CFG, 32'h8000_0040, "R6 result cleared");
    bus_read(A_RAW, 32'h0, "R6 raw cleared");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R9 missing reads actual %0d expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule